// File: doc/BRIEF.md
# Paged DMA Address Translator

This block turns 32-bit addresses issued by a DMA engine into physical addresses. It uses a flat page table that lives in system memory. Software programs two registers: the table's start address and the table's length in bytes. Each request is split into a page number and an offset within the page. The page number is checked against the table length. A table slot that lies within the table is then read over a memory read port. The response carries either the physical address or a fault flag.

Only one translation is open at any time. A request port, a response port and a memory request port each use a valid/ready handshake. The memory read response is accepted as soon as it is valid. Entries are not cached, so every in-range request costs one memory read.

Top module: `dma_page_xlat`

## Requirements
- R1: The page size is 4096 bytes. The page number is `req_addr[31:12]`, and `req_addr[11:0]` appears unchanged in `rsp_paddr[11:0]` of every successful translation.
- R2: A table slot is 8 bytes, returned as one 64-bit `mem_rsp_data` word. The frame word sits at the lower address and arrives in bits 31:0. Bits 63:32 hold an owner word that has no effect on any result.
- R3: A request is in range only when its page number is less than the limit register divided by 8, rounded down. An out-of-range request returns `rsp_fault`=1 with `rsp_paddr`=0 and issues no memory read.
- R4: For an in-range request the memory read address equals the base register with bit 31 forced to 0, plus the page number times 8.
- R5: A successful translation returns `rsp_fault`=0 and `rsp_paddr` = {frame word bits 31:12, request offset}.
- R6: When `mem_rsp_err` is 1 on the table read, the response is `rsp_fault`=1 with `rsp_paddr`=0.
- R7: The register port holds the base at byte offset 0x18 and the limit at 0x20. Both are 32 bits and can be written and read back. A write to 0x28, or to any other offset, changes neither register. Reads at any other offset return 0.
- R8: After a request is accepted, `req_ready` stays 0 until the response handshake completes. While `rsp_ready` is 0, the response holds its value.
- R9: Reset clears base and limit to 0, drives `req_ready` to 1, and drives `rsp_valid` and `mem_req_valid` to 0. A request made before the table is programmed faults.
- R10: `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Ready for a new request |
| req_addr | input | 32 | Device address to translate |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted |
| rsp_paddr | output | 32 | Physical address, or 0 on fault |
| rsp_fault | output | 1 | Translation failed |
| mem_req_valid | output | 1 | Table read request valid |
| mem_req_ready | input | 1 | Table read request accepted |
| mem_req_addr | output | 32 | Byte address of the table slot |
| mem_rsp_valid | input | 1 | Table read data valid |
| mem_rsp_data | input | 64 | Table slot: frame word in 31:0, owner word in 63:32 |
| mem_rsp_err | input | 1 | Table read failed |

## Verification
The bench uses the default parameters: 4 KiB pages, 32-bit addresses and an 8-bit register offset. With these defaults, sweeping pages 0 to 33 under limits of 0, 7, 8, 15, 16, 100 and 256 reaches every edge of the divide-by-8 range test, including limits that are not multiples of 8. The memory model computes each frame word and error flag from the page number and puts a scrambled owner word in the upper half, so a wrong word choice or a missed error changes the result. A final pass with the largest possible limit and a base that has bit 31 set reaches the top page number and exercises the bit-31 masking of the slot address.

// File: rtl/dma_xlat_pkg.sv
package dma_xlat_pkg;

    localparam int AW          = 32;
    localparam int PAGE_BITS_D = 12;
    localparam int SLOT_SHIFT  = 3;
    localparam int SLOT_W      = 64;
    localparam int REG_AW_D    = 8;

    localparam logic [REG_AW_D-1:0] OFS_BASE  = 8'h18;
    localparam logic [REG_AW_D-1:0] OFS_LIMIT = 8'h20;
    localparam logic [REG_AW_D-1:0] OFS_INVAL = 8'h28;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_RESP
    } xlat_state_e;

    typedef struct packed {
        logic [AW-1:0] paddr;
        logic          fault;
    } xlat_result_t;

    localparam xlat_result_t RES_FAULT = '{paddr: '0, fault: 1'b1};

    function automatic logic [AW-1:0] clear_top(input logic [AW-1:0] v);
        logic [AW-1:0] m;
        m = '1;
        m[AW-1] = 1'b0;
        return v & m;
    endfunction

endpackage

// File: rtl/xlat_regs.sv
module xlat_regs
    import dma_xlat_pkg::*;
#(
    parameter int REG_AW = REG_AW_D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [AW-1:0]     wdata,
    output logic [AW-1:0]     rdata,
    output logic [AW-1:0]     base_o,
    output logic [AW-1:0]     limit_o
);

    logic [AW-1:0] base_q;
    logic [AW-1:0] limit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            limit_q <= '0;
        end else if (wr_en) begin
            if (addr == REG_AW'(OFS_BASE))
                base_q <= wdata;
            else if (addr == REG_AW'(OFS_LIMIT))
                limit_q <= wdata;
        end
    end

    always_comb begin
        if (addr == REG_AW'(OFS_BASE))
            rdata = base_q;
        else if (addr == REG_AW'(OFS_LIMIT))
            rdata = limit_q;
        else
            rdata = '0;
    end

    assign base_o  = base_q;
    assign limit_o = limit_q;

    p_inval_no_effect_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == REG_AW'(OFS_INVAL)) |=> ($stable(base_q) && $stable(limit_q)));

    p_reset_clear_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (base_q == '0 && limit_q == '0));

endmodule

// File: rtl/xlat_check.sv
module xlat_check
    import dma_xlat_pkg::*;
#(
    parameter int PAGE_BITS = PAGE_BITS_D
) (
    input  logic [AW-1:0] req_addr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] limit,
    output logic          in_range,
    output logic [AW-1:0] slot_addr
);

    localparam int IDX_W = AW - PAGE_BITS;

    logic [IDX_W-1:0] page_idx;
    logic [AW-1:0]    idx_ext;
    logic [AW-1:0]    slot_count;
    logic [AW-1:0]    slot_ofs;

    always_comb begin
        page_idx   = req_addr[AW-1:PAGE_BITS];
        idx_ext    = AW'(page_idx);
        slot_count = limit >> SLOT_SHIFT;
        in_range   = idx_ext < slot_count;
        slot_ofs   = idx_ext << SLOT_SHIFT;
        slot_addr  = clear_top(base) + slot_ofs;
    end

    logic unused_low;
    assign unused_low = ^req_addr[PAGE_BITS-1:0];

endmodule

// File: rtl/xlat_fsm.sv
module xlat_fsm
    import dma_xlat_pkg::*;
#(
    parameter int PAGE_BITS = PAGE_BITS_D
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [PAGE_BITS-1:0] req_offset,
    input  logic                 in_range,
    input  logic [AW-1:0]        slot_addr,
    output logic                 mem_req_valid,
    input  logic                 mem_req_ready,
    output logic [AW-1:0]        mem_req_addr,
    input  logic                 mem_rsp_valid,
    input  logic [SLOT_W-1:0]    mem_rsp_data,
    input  logic                 mem_rsp_err,
    output logic                 rsp_valid,
    input  logic                 rsp_ready,
    output logic [AW-1:0]        rsp_paddr,
    output logic                 rsp_fault
);

    xlat_state_e          state_q;
    logic [PAGE_BITS-1:0] ofs_q;
    logic [AW-1:0]        slot_q;
    xlat_result_t         res_q;
    xlat_result_t         hit_res;

    always_comb begin
        hit_res.paddr = {mem_rsp_data[AW-1:PAGE_BITS], ofs_q};
        hit_res.fault = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ofs_q   <= '0;
            slot_q  <= '0;
            res_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    ofs_q  <= req_offset;
                    slot_q <= slot_addr;
                    if (in_range) begin
                        state_q <= ST_FETCH;
                    end else begin
                        res_q   <= RES_FAULT;
                        state_q <= ST_RESP;
                    end
                end
                ST_FETCH: if (mem_req_ready) state_q <= ST_WAIT;
                ST_WAIT: if (mem_rsp_valid) begin
                    res_q   <= mem_rsp_err ? RES_FAULT : hit_res;
                    state_q <= ST_RESP;
                end
                ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready     = (state_q == ST_IDLE);
    assign mem_req_valid = (state_q == ST_FETCH);
    assign mem_req_addr  = slot_q;
    assign rsp_valid     = (state_q == ST_RESP);
    assign rsp_paddr     = res_q.paddr;
    assign rsp_fault     = res_q.fault;

    logic unused_owner;
    assign unused_owner = ^{mem_rsp_data[SLOT_W-1:AW], mem_rsp_data[PAGE_BITS-1:0]};

    p_rsp_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

    p_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid || mem_req_valid) |-> !req_ready);

    p_mem_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    p_fault_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

    p_no_rsp_in_fetch_r3: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !rsp_valid);

    p_offset_kept_r1: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_fault) |-> (rsp_paddr[PAGE_BITS-1:0] == ofs_q));

endmodule

// File: rtl/dma_page_xlat.sv
module dma_page_xlat
    import dma_xlat_pkg::*;
#(
    parameter int PAGE_BITS = PAGE_BITS_D,
    parameter int REG_AW    = REG_AW_D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_addr,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [31:0]       rsp_paddr,
    output logic              rsp_fault,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [31:0]       mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [63:0]       mem_rsp_data,
    input  logic              mem_rsp_err
);

    logic [AW-1:0] base_w;
    logic [AW-1:0] limit_w;
    logic          in_range_w;
    logic [AW-1:0] slot_addr_w;

    xlat_regs #(.REG_AW(REG_AW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr_en),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .base_o  (base_w),
        .limit_o (limit_w)
    );

    xlat_check #(.PAGE_BITS(PAGE_BITS)) u_check (
        .req_addr  (req_addr),
        .base      (base_w),
        .limit     (limit_w),
        .in_range  (in_range_w),
        .slot_addr (slot_addr_w)
    );

    xlat_fsm #(.PAGE_BITS(PAGE_BITS)) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_offset    (req_addr[PAGE_BITS-1:0]),
        .in_range      (in_range_w),
        .slot_addr     (slot_addr_w),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .mem_rsp_err   (mem_rsp_err),
        .rsp_valid     (rsp_valid),
        .rsp_ready     (rsp_ready),
        .rsp_paddr     (rsp_paddr),
        .rsp_fault     (rsp_fault)
    );

endmodule

// File: tb/dma_page_xlat_tb.sv
module dma_page_xlat_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        mem_rsp_err = 1'b0;

    int checks = 0;
    int fails  = 0;
    int fetches = 0;
    logic [31:0] cur_base = '0;
    logic [31:0] cur_limit = '0;
    logic [31:0] last_fetch_addr = '0;

    always #5 clk = ~clk;

    dma_page_xlat u_dut (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err)
    );

    function automatic logic [31:0] frame_of(input logic [31:0] idx);
        return (idx * 32'h0001_3000) ^ 32'hA5A5_5A5A;
    endfunction

    function automatic logic err_of(input logic [31:0] idx);
        return (idx % 7) == 5;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // memory model: accepts one table read, answers one cycle later
    initial begin
        int ph = 0;
        logic [31:0] idx;
        forever begin
            @(posedge clk); #1;
            mem_rsp_valid = 1'b0;
            if (ph == 1) begin
                mem_req_ready = 1'b0;
                idx = (last_fetch_addr - (cur_base & 32'h7FFF_FFFF)) >> 3;
                mem_rsp_data = {~frame_of(idx) ^ 32'h0000_1FFF, frame_of(idx)};
                mem_rsp_err = err_of(idx);
                mem_rsp_valid = 1'b1;
                ph = 0;
            end else if (mem_req_valid) begin
                mem_req_ready = 1'b1;
                last_fetch_addr = mem_req_addr;
                fetches++;
                ph = 1;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr_en = 1'b0;
        if (a == 8'h18) cur_base = d;
        if (a == 8'h20) cur_limit = d;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a; #1;
        d = reg_rdata;
    endtask

    task automatic xlate(input logic [31:0] a, input bit hold);
        logic [31:0] idx, exp_pa, exp_slot, held;
        logic inr, exp_f, acc;
        int f0, guard;
        idx = a >> 12;
        inr = idx < (cur_limit >> 3);
        exp_slot = (cur_base & 32'h7FFF_FFFF) + idx * 8;
        if (!inr)              begin exp_f = 1'b1; exp_pa = '0; end
        else if (err_of(idx))  begin exp_f = 1'b1; exp_pa = '0; end
        else begin exp_f = 1'b0; exp_pa = {frame_of(idx)[31:12], a[11:0]}; end
        f0 = fetches;
        req_valid = 1'b1; req_addr = a;
        do begin acc = req_ready; @(posedge clk); #1; end while (!acc);
        req_valid = 1'b0;
        guard = 0;
        while (!rsp_valid && guard < 50) begin @(posedge clk); #1; guard++; end
        chk(rsp_valid, "R8 response arrives", 64'(rsp_valid), 1);
        chk(!req_ready, "R8 busy while response open", 64'(req_ready), 0);
        chk(rsp_fault == exp_f, inr ? "R6 fault flag" : "R3 range fault", 64'(rsp_fault), 64'(exp_f));
        chk(rsp_paddr == exp_pa, "R5 R1 R2 physical address", 64'(rsp_paddr), 64'(exp_pa));
        if (inr) begin
            chk(fetches == f0 + 1, "R4 one table read", 64'(fetches - f0), 1);
            chk(last_fetch_addr == exp_slot, "R4 slot address", 64'(last_fetch_addr), 64'(exp_slot));
        end else begin
            chk(fetches == f0, "R3 no table read out of range", 64'(fetches - f0), 0);
        end
        if (hold) begin
            held = rsp_paddr;
            @(posedge clk); #1;
            chk(rsp_valid && rsp_paddr == held, "R8 response held", 64'(rsp_paddr), 64'(held));
        end
        rsp_ready = 1'b1;
        @(posedge clk); #1;
        rsp_ready = 1'b0;
        chk(!rsp_valid && req_ready, "R8 ready after handshake", 64'({rsp_valid, req_ready}), 64'b01);
    endtask

    initial begin
        logic [31:0] d;
        int lims [7] = '{0, 7, 8, 15, 16, 100, 256};
        repeat (3) @(posedge clk); #1;
        rst = 1'b0;
        chk(req_ready && !rsp_valid && !mem_req_valid, "R9 reset outputs",
            64'({req_ready, rsp_valid, mem_req_valid}), 64'b100);
        reg_read(8'h18, d); chk(d == 0, "R9 base reset", 64'(d), 0);
        reg_read(8'h20, d); chk(d == 0, "R9 limit reset", 64'(d), 0);
        xlate(32'h0000_0ABC, 1'b0);  // R9: faults before programming

        reg_write(8'h18, 32'h8000_0100);
        reg_read(8'h18, d); chk(d == 32'h8000_0100, "R7 base readback", 64'(d), 64'h8000_0100);
        reg_write(8'h20, 32'hDEAD_BEEF);
        reg_read(8'h20, d); chk(d == 32'hDEAD_BEEF, "R7 limit readback", 64'(d), 64'hDEAD_BEEF);
        reg_write(8'h28, 32'h1234_5678);
        reg_write(8'h30, 32'h0BAD_F00D);
        reg_read(8'h18, d); chk(d == 32'h8000_0100, "R7 base kept after 0x28 write", 64'(d), 64'h8000_0100);
        reg_read(8'h20, d); chk(d == 32'hDEAD_BEEF, "R7 limit kept after 0x28 write", 64'(d), 64'hDEAD_BEEF);
        reg_read(8'h30, d); chk(d == 0, "R7 unmapped reads zero", 64'(d), 0);

        foreach (lims[li]) begin
            reg_write(8'h20, 32'(lims[li]));
            for (int p = 0; p < 34; p++)
                xlate((32'(p) << 12) | ((32'(p) * 397 + 32'(lims[li])) & 32'hFFF), (p % 3) == 0);
        end

        reg_write(8'h18, 32'hC000_2000);
        reg_write(8'h20, 32'hFFFF_FFFF);
        xlate(32'hFFFF_FFFF, 1'b1);
        xlate(32'h8000_0000, 1'b0);
        xlate(32'h1234_5FFF, 1'b0);
        xlate(32'h0000_0000, 1'b0);
        summary();
    end

endmodule